// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This controller connects a clocked single-beat request bus to an external asynchronous static RAM of 32K bytes. The memory has a 15-bit address, a shared 8-bit data bus and three active-low strobes: chip select, output enable and write enable. Every accepted request becomes a pin sequence in which each phase lasts a whole number of clock cycles. Those counts come from nanosecond timing parameters divided by the clock period and rounded up, with a floor of one cycle.

A requester raises `req_valid` with the direction, address and write data, and holds them until `req_ack` pulses for one cycle. Requests are sampled only while the controller is idle. A read drops chip select and output enable for the read window. The byte on the data bus is registered on the last cycle of that window, and the acknowledge follows with both strobes released. A write drops chip select with write enable still high and the data already driven. It then pulses write enable low for the write window and raises it again one cycle before it lets go of chip select, address and data. The controller owns the data-bus driver enable. After any read it keeps the driver off until the memory's outputs have had time to float.

Top module: `sram_port_ctrl`

## Requirements
- R1: In reset and when idle, chip select, output enable and write enable are all high, the data driver enable is low and the acknowledge is low; the read data register resets to 0.
- R2: A read holds chip select and output enable low, with write enable high, for RD_CYC cycles, where RD_CYC = max(1, ceil(max(tRC, tAA, tDOE) / clock period)); the address pins carry the accepted address throughout.
- R3: The read data register takes the data-bus value on the last read cycle. In the next cycle `req_ack` is high for exactly one cycle, with chip select and output enable back high, and `rsp_rdata` carries that byte.
- R4: A write runs as follows. First comes one setup cycle with chip select low, write enable high and the data driven. Then write enable stays low for WE_CYC = max(1, ceil(max(tPWE, tSD, tAW) / period), ceil(tWC / period) - 2) cycles. Last comes one cycle with write enable high and chip select low, in which address and data still drive and `req_ack` is high.
- R5: After the read acknowledge cycle the controller waits HZ_CYC - 1 further cycles, where HZ_CYC = max(1, ceil(tHZ / period)), before it returns to idle. The data driver is never enabled within HZ_CYC cycles of output enable rising.
- R6: Output enable and write enable are never low together, and the data driver is never enabled while output enable is low.
- R7: Changes on `req_addr`, `req_wdata` and `req_write` after acceptance do not affect the address, data or strobe pins of the transfer in progress.
- R8: A request is accepted only at the end of an idle cycle. A request held high during the acknowledge or recovery cycles starts only after one full idle cycle. Each request gets exactly one single-cycle acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read |
| mem_addr | output | 15 | Address pins of the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data-bus driver enable |
| mem_dq_in | input | 8 | Value sampled from the data bus |

## Verification
The bench attaches a behavioural memory that returns wrong data until the full read latency has passed. That memory keeps driving the bus for HZ_CYC cycles after output enable rises. So a read window that is too short returns corrupted bytes, and an early driver turn-on is reported as bus contention. Writes with a short pulse, or with data that is not driven for the whole window, fail the memory's own width and drive checks. The final contents comparison shows any write committed to the wrong address. Requests are also held high through the acknowledge and recovery cycles, and the request fields are scrambled during a transfer. An FSM that accepts outside idle, or a pin register that follows the live inputs, then drifts from the per-cycle reference.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and cycle arithmetic for the asynchronous SRAM controller.
// Assumes all timing values are positive nanosecond integers.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACT,
        ST_RD_END,
        ST_TURN,
        ST_WR_SET,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctrl_state_e;

    // Round a nanosecond span up to clock cycles, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned span_ns,
                                              input int unsigned period_ns);
        int unsigned c;
        c = (span_ns + period_ns - 1) / period_ns;
        return (c == 0) ? 1 : c;
    endfunction

    // Larger of two cycle counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that measures the length of one pin phase.
// Loaded with (cycles - 1) on entry to a phase; done is high on the last cycle.
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
// Sequencer for read and write transfers. Decides the next phase and
// programs the phase timer. Requests are taken only in ST_IDLE.
// Assumes RD_CYC, WE_CYC and HZ_CYC are all at least one.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned RD_CYC = 9,
    parameter int unsigned WE_CYC = 8,
    parameter int unsigned HZ_CYC = 4,
    parameter int unsigned CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_done,
    output ctrl_state_e      state_q,
    output ctrl_state_e      state_d,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             rd_last
);

    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WE_LOAD   = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'((HZ_CYC > 1) ? HZ_CYC - 2 : 0);
    localparam bit               NEED_TURN = (HZ_CYC > 1);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign rd_last = (state_q == ST_RD_ACT) && tmr_done;

    // Next phase and timer programming.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_d = ST_WR_SET;
                    end else begin
                        state_d  = ST_RD_ACT;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end
                end
            end
            ST_RD_ACT: begin
                if (tmr_done)
                    state_d = ST_RD_END;
            end
            ST_RD_END: begin
                if (NEED_TURN) begin
                    state_d  = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = TURN_LOAD;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_TURN: begin
                if (tmr_done)
                    state_d = ST_IDLE;
            end
            ST_WR_SET: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = WE_LOAD;
            end
            ST_WR_PULSE: begin
                if (tmr_done)
                    state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/sram_pin_reg.sv
// Output register stage for the memory pins. Strobes and the driver enable
// are decoded from the next phase and registered, so pins change only on
// clock edges. Address and write data are held from acceptance until the
// next acceptance. Read data is captured on the last read cycle.
module sram_pin_reg
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned AW = 15,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_state_e   state_d,
    input  logic          accept,
    input  logic          rd_last,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_dq_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_dq_oe,
    output logic [DW-1:0] rsp_rdata
);

    logic sel_d, oe_d, we_d, drv_d;

    // Pin levels wanted in the next phase.
    always_comb begin
        sel_d = (state_d == ST_RD_ACT) || (state_d == ST_WR_SET) ||
                (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
        oe_d  = (state_d == ST_RD_ACT);
        we_d  = (state_d == ST_WR_PULSE);
        drv_d = (state_d == ST_WR_SET) || (state_d == ST_WR_PULSE) ||
                (state_d == ST_WR_HOLD);
    end

    // Registered strobes and driver enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_ce_n  <= ~sel_d;
            mem_oe_n  <= ~oe_d;
            mem_we_n  <= ~we_d;
            mem_dq_oe <= drv_d;
        end
    end

    // Address and write data, latched once per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Read data capture on the final read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_rdata <= '0;
        else if (rd_last)
            rsp_rdata <= mem_dq_in;
    end

endmodule

// File: rtl/sram_port_ctrl.sv
// Top level of the asynchronous SRAM controller. Converts single-beat
// requests into chip-select / output-enable / write-enable sequences with
// phase lengths computed from nanosecond timing and the clock period.
// Assumes the requester holds its request stable until req_ack, and that
// the external bus is resolved outside this block from mem_dq_out/mem_dq_oe.
module sram_port_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned AW     = 15,
    parameter int unsigned DW     = 8,
    parameter int unsigned CLK_NS = 8,
    parameter int unsigned RC_NS  = 70,
    parameter int unsigned AA_NS  = 70,
    parameter int unsigned DOE_NS = 35,
    parameter int unsigned HZ_NS  = 25,
    parameter int unsigned WC_NS  = 70,
    parameter int unsigned PWE_NS = 50,
    parameter int unsigned SD_NS  = 30,
    parameter int unsigned AW_NS  = 60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);

    localparam int unsigned RD_CYC =
        ns_to_cyc(max2(max2(RC_NS, AA_NS), DOE_NS), CLK_NS);
    localparam int unsigned WC_CYC = ns_to_cyc(WC_NS, CLK_NS);
    localparam int unsigned WE_CYC =
        max2(ns_to_cyc(max2(max2(PWE_NS, SD_NS), AW_NS), CLK_NS),
             (WC_CYC > 2) ? WC_CYC - 2 : 1);
    localparam int unsigned HZ_CYC = ns_to_cyc(HZ_NS, CLK_NS);
    localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WE_CYC), HZ_CYC);
    localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

    ctrl_state_e      state_q, state_d;
    logic             tmr_load, tmr_done, accept, rd_last;
    logic [CNT_W-1:0] tmr_val;

    sram_seq_fsm #(
        .RD_CYC (RD_CYC),
        .WE_CYC (WE_CYC),
        .HZ_CYC (HZ_CYC),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_done  (tmr_done),
        .state_q   (state_q),
        .state_d   (state_d),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .rd_last   (rd_last)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_pin_reg #(
        .AW (AW),
        .DW (DW)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_d    (state_d),
        .accept     (accept),
        .rd_last    (rd_last),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_oe  (mem_dq_oe),
        .rsp_rdata  (rsp_rdata)
    );

    // Acknowledge during the read-release cycle or the write-hold cycle.
    assign req_ack = (state_q == ST_RD_END) || (state_q == ST_WR_HOLD);

endmodule

// File: rtl/sram_port_chk.sv
// Protocol checker for sram_port_ctrl, attached with bind. Watches the
// memory pins and the acknowledge only.
module sram_port_chk #(
    parameter int unsigned AW     = 15,
    parameter int unsigned DW     = 8,
    parameter int unsigned RD_CYC = 9,
    parameter int unsigned WE_CYC = 8,
    parameter int unsigned HZ_CYC = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ack,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe
);

    logic [15:0] oe_low_cnt, we_low_cnt, oe_high_cnt;

    // Length of the current output-enable and write-enable low stretches,
    // and cycles since output enable last went high (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_low_cnt  <= '0;
            we_low_cnt  <= '0;
            oe_high_cnt <= 16'hFFFF;
        end else begin
            oe_low_cnt  <= mem_oe_n ? 16'd0 : oe_low_cnt + 16'd1;
            we_low_cnt  <= mem_we_n ? 16'd0 : we_low_cnt + 16'd1;
            if (!mem_oe_n)
                oe_high_cnt <= '0;
            else if (oe_high_cnt != 16'hFFFF)
                oe_high_cnt <= oe_high_cnt + 16'd1;
        end
    end

    // R2
    rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_low_cnt == 16'(RD_CYC)));

    // R3
    rd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> req_ack);

    // R4
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == 16'(WE_CYC)));

    // R4
    we_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (!mem_ce_n && $past(!mem_ce_n) && mem_dq_oe));

    // R4
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && req_ack &&
                             $stable(mem_addr) && $stable(mem_dq_out)));

    // R5
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (oe_high_cnt >= 16'(HZ_CYC)));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R6
    drive_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

endmodule

bind sram_port_ctrl sram_port_chk #(
    .AW     (AW),
    .DW     (DW),
    .RD_CYC (RD_CYC),
    .WE_CYC (WE_CYC),
    .HZ_CYC (HZ_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ack    (req_ack),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_port_ctrl.sv
// Bench: per-cycle reference queue of expected pin states, plus a
// behavioural memory with read latency, float delay and write checks.
module test_sram_port_ctrl;

    localparam int P_NS = 8;
    localparam int T_RC = 70, T_AA = 70, T_DOE = 35, T_HZ = 25;
    localparam int T_WC = 70, T_PWE = 50, T_SD = 30, T_AW = 60;

    function automatic int up(input int ns);
        int c;
        c = (ns + P_NS - 1) / P_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int RD_N = (up(T_RC) > up(T_AA)) ?
        ((up(T_RC) > up(T_DOE)) ? up(T_RC) : up(T_DOE)) :
        ((up(T_AA) > up(T_DOE)) ? up(T_AA) : up(T_DOE));
    localparam int WE_A = (up(T_PWE) > up(T_SD)) ?
        ((up(T_PWE) > up(T_AW)) ? up(T_PWE) : up(T_AW)) :
        ((up(T_SD) > up(T_AW)) ? up(T_SD) : up(T_AW));
    localparam int WE_N = (WE_A > up(T_WC) - 2) ? WE_A : up(T_WC) - 2;
    localparam int HZ_N = up(T_HZ);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ack;
    logic [7:0]  rsp_rdata;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h00;

    always #4 clk = ~clk;

    sram_port_ctrl #(
        .CLK_NS(P_NS), .RC_NS(T_RC), .AA_NS(T_AA), .DOE_NS(T_DOE), .HZ_NS(T_HZ),
        .WC_NS(T_WC), .PWE_NS(T_PWE), .SD_NS(T_SD), .AW_NS(T_AW)
    ) i_sram_port_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0, n_bad = 0;
    bit started = 0, finished = 0;

    typedef struct {
        logic ce, oe, we, drv, ack;
        logic chk_addr, chk_dq, chk_rd;
        logic [14:0] addr;
        logic [7:0] dq, rd;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    logic [7:0] ext_mem[int];
    logic [7:0] ref_mem[int];

    function automatic logic [7:0] fill(input int a);
        logic [14:0] aa;
        aa = 15'(a);
        return aa[7:0] ^ {aa[14:8], 1'b1};
    endfunction

    function automatic logic [7:0] ext_rd(input int a);
        return ext_mem.exists(a) ? ext_mem[a] : fill(a);
    endfunction

    function automatic logic [7:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : fill(a);
    endfunction

    function automatic exp_t idle_e(input string tag);
        exp_t e;
        e = '{ce:1, oe:1, we:1, drv:0, ack:0, chk_addr:0, chk_dq:0, chk_rd:0,
              addr:'0, dq:'0, rd:'0, tag:tag};
        return e;
    endfunction

    task automatic note(input bit ok, input string tag, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // Per-cycle comparison against the reference queue (idle when empty).
    always @(negedge clk) begin
        if (started && rst_n && !finished) begin
            exp_t e;
            bit ok;
            e = (exp_q.size() != 0) ? exp_q.pop_front() : idle_e("R1");
            ok = (mem_ce_n == e.ce) && (mem_oe_n == e.oe) && (mem_we_n == e.we) &&
                 (mem_dq_oe == e.drv) && (req_ack == e.ack) &&
                 (!e.chk_addr || mem_addr == e.addr) &&
                 (!e.chk_dq || mem_dq_out == e.dq) &&
                 (!e.chk_rd || rsp_rdata == e.rd);
            note(ok, e.tag, $sformatf(
                "pins ce/oe/we/drv/ack=%b%b%b%b%b addr=%h dq=%h rd=%h expected %b%b%b%b%b addr=%h dq=%h rd=%h",
                mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ack, mem_addr, mem_dq_out, rsp_rdata,
                e.ce, e.oe, e.we, e.drv, e.ack, e.addr, e.dq, e.rd));
        end
    end

    // Behavioural memory: read latency, output float delay, write commit.
    int rd_cnt = 0, hz_left = 0, we_cnt = 0;
    bit wr_prev = 0;
    logic [14:0] wr_a;
    logic [7:0]  wr_d;
    always @(negedge clk) begin
        if (started && rst_n && !finished) begin
            bit rd_act, wr_act, mem_drives;
            rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;
            wr_act = !mem_ce_n && !mem_we_n;
            mem_drives = rd_act || (hz_left > 0);
            if (mem_dq_oe && mem_drives)
                note(0, "R6", $sformatf("driver on while memory drives, hz_left=%0d expected memory floating", hz_left));
            if (!mem_oe_n && !mem_we_n)
                note(0, "R6", "oe and we both low, expected never");
            if (rd_act) begin
                rd_cnt++;
                hz_left = HZ_N;
                mem_dq_in = (rd_cnt >= RD_N) ? ext_rd(int'(mem_addr)) : ~ext_rd(int'(mem_addr));
            end else begin
                rd_cnt = 0;
                if (hz_left > 0) hz_left--;
            end
            if (wr_act) begin
                if (!wr_prev) begin
                    wr_a = mem_addr;
                    wr_d = mem_dq_out;
                end
                if (!mem_dq_oe || mem_dq_out != wr_d || mem_addr != wr_a)
                    note(0, "R4", $sformatf("write window unstable drv=%b a=%h d=%h expected 1 %h %h",
                                            mem_dq_oe, mem_addr, mem_dq_out, wr_a, wr_d));
                we_cnt++;
            end else if (wr_prev) begin
                note(we_cnt >= WE_N, "R4", $sformatf("write pulse %0d cycles expected >= %0d", we_cnt, WE_N));
                ext_mem[int'(wr_a)] = wr_d;
                we_cnt = 0;
            end
            wr_prev = wr_act;
        end
    end

    // Issue one request, push its expected cycles, wait for its acknowledge.
    task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d,
                         input bit early, input bit wiggle, input string tg);
        exp_t e;
        int guard;
        while (exp_q.size() != 0) begin @(negedge clk); #1; end
        if (!early) begin @(negedge clk); #1; end
        else exp_q.push_back(idle_e("R8"));
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        if (wr) begin
            e = '{ce:0, oe:1, we:1, drv:1, ack:0, chk_addr:1, chk_dq:1, chk_rd:0,
                  addr:a, dq:d, rd:'0, tag:tg};
            exp_q.push_back(e);
            e.we = 0;
            for (int i = 0; i < WE_N; i++) exp_q.push_back(e);
            e.we = 1; e.ack = 1;
            exp_q.push_back(e);
            ref_mem[int'(a)] = d;
        end else begin
            e = '{ce:0, oe:0, we:1, drv:0, ack:0, chk_addr:1, chk_dq:0, chk_rd:0,
                  addr:a, dq:'0, rd:'0, tag:tg};
            for (int i = 0; i < RD_N; i++) exp_q.push_back(e);
            e = idle_e((tg == "R2") ? "R3" : tg);
            e.ack = 1; e.chk_rd = 1; e.rd = ref_rd(int'(a));
            exp_q.push_back(e);
            for (int i = 1; i < HZ_N; i++) exp_q.push_back(idle_e("R5"));
        end
        guard = 0;
        do begin
            @(negedge clk); #1;
            guard++;
            if (wiggle) begin
                req_addr = req_addr ^ 15'h1F0F;
                req_wdata = ~req_wdata;
                req_write = ~req_write;
            end
        end while (!req_ack && guard < 200);
        req_valid = 1'b0;
    endtask

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, cycles=%0d expected < 20000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            note(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ack && rsp_rdata == 8'h00,
                 "R1", $sformatf("reset pins ce/oe/we/drv/ack=%b%b%b%b%b rd=%h expected 11100 00",
                                 mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ack, rsp_rdata));
        end
        #1 rst_n = 1'b1;
        started = 1;
        repeat (4) @(negedge clk);                          // R1 idle, R8 no request
        issue(0, 15'h0000, 8'h00, 0, 0, "R2");               // read unwritten
        issue(1, 15'h7FFF, 8'h3C, 0, 0, "R4");               // write top address
        issue(0, 15'h7FFF, 8'h00, 0, 0, "R2");               // read it back
        issue(1, 15'h0001, 8'hA5, 1, 0, "R8");               // request held through recovery
        issue(1, 15'h0002, 8'h5A, 1, 0, "R8");               // request held through write ack
        issue(0, 15'h0001, 8'h00, 1, 0, "R8");
        issue(1, 15'h1234, 8'hC3, 0, 1, "R7");               // inputs scrambled mid-write
        issue(0, 15'h1234, 8'h00, 0, 1, "R7");               // inputs scrambled mid-read
        issue(0, 15'h0002, 8'h00, 0, 0, "R2");
        for (int k = 0; k < 16; k++) begin
            logic [14:0] a;
            a = 15'((k * 2731 + 17) & 32'h7FFF);
            issue(1, a, 8'((k * 37) ^ 8'h96), k[0], 0, "R4");
            issue(0, a, 8'h00, k[1], 0, "R5");
        end
        while (exp_q.size() != 0) begin @(negedge clk); #1; end
        repeat (4) @(negedge clk);
        finished = 1;
        foreach (ref_mem[a])
            note(ext_rd(a) == ref_mem[a], "R4",
                 $sformatf("memory[%h]=%h expected %h", a, ext_rd(a), ref_mem[a]));
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule